// File: doc/BRIEF.md
# HDLC Serial Receive Channel

This block recovers HDLC frames from a synchronous serial line. One bit is sampled on every rising edge of the line clock. Flags mark the start and end of each frame. The block deletes the zeros that the sender stuffed into the data, and it stops a frame when it sees an abort pattern. It assembles bytes least significant bit first and checks the frame check sequence (FCS) when the closing flag arrives. Payload bytes go to a backend one at a time through a ready/read handshake. The FCS bytes are used for checking and are never delivered.

The block has no registers or counters that software can see. It exports only the data byte and three status levels. The backend uses `frame_valid` to bracket a frame. It treats a pulse of `frame_err` at the closing flag, or a held `frame_err` during the frame, as a reason to drop that frame. The FCS width is chosen at build time with `CRC_W`.

The control state machine has three states. `RX_HUNT` waits for a flag and ignores data bits. `RX_OPEN` means a flag has been seen and no frame bit has yet left the flag lag. `RX_RECV` means a frame is in progress and `frame_valid` is high. The transitions are:
- `RX_HUNT` goes to `RX_OPEN` on a flag.
- `RX_OPEN` stays in `RX_OPEN` on a repeated flag.
- `RX_OPEN` goes to `RX_RECV` when the first data bit leaves the lag.
- `RX_RECV` goes back to `RX_OPEN` on the closing flag.
- `RX_OPEN` and `RX_RECV` go to `RX_HUNT` on an abort.

Top module: `hdlc_rx_channel`

## Requirements
- R1: The flag is the bit pattern 0x7E, that is a zero, six ones and a zero. `frame_valid` rises on the edge that samples the seventh unstuffed data bit after a flag. It falls on the edge that samples the last zero of the closing flag. A closing flag also opens the next frame.
- R2: A zero that follows exactly five consecutive ones is removed and does not enter byte assembly.
- R3: The seventh consecutive one is an abort. On the same edge `frame_valid` goes low and no `frame_err` is raised. Nothing more is delivered until a new flag.
- R4: Bytes are assembled least significant bit first. A byte reaches `rx_data` with `rx_ready` high only once `CRC_W/8` further bytes have been received, so the trailing FCS bytes are never delivered.
- R5: If the number of data bits between the flags is not a multiple of eight, `frame_err` is high for one cycle on the closing-flag edge.
- R6: If the FCS residue check fails, `frame_err` is high for one cycle on the closing-flag edge.
- R7: If a frame holds fewer than `CRC_W/8 + 1` whole bytes, `frame_err` is high for one cycle on the closing-flag edge.
- R8: If `rd_strobe` is sampled high on any of the seven edges that follow the edge where `rx_ready` rose, `rx_ready` falls on that edge and no error is raised.
- R9: If no read occurs in those seven edges, `rx_ready` falls on the seventh edge. `frame_err` then rises and stays high until `frame_valid` falls.
- R10: `rd_strobe` has no effect while `rx_ready` is low.
- R11: With `CRC_W` = 16 the FCS uses the reflected polynomial 0x8408, a preset of all ones and a good residue of 0xF0B8. With `CRC_W` = 32 it uses 0xEDB88320, all ones, and a residue of 0xDEBB20E3.
- R12: A run of back-to-back flags with no data between them produces no frame: `frame_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock; one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_bit | input | 1 | Serial receive data |
| rd_strobe | input | 1 | Backend takes the byte on `rx_data` |
| rx_data | output | 8 | Delivered payload byte |
| rx_ready | output | 1 | A payload byte is waiting |
| frame_valid | output | 1 | A frame is in progress |
| frame_err | output | 1 | Framing, FCS, length or late-read error |

## Verification
The assertions check the following on every cycle:
- a closing flag ends an open frame;
- an abort drops `frame_valid` without an error;
- bytes are offered only inside a frame;
- a read clears `rx_ready`;
- `rx_ready` is never held for more than seven edges;
- idle flags keep `frame_valid` low.

Some behaviour can only be shown by the bench's scenarios. These include correct zero deletion and LSB-first order, withholding of the FCS bytes, and the separate error causes: misalignment, a bad residue, a short frame and a late read. They also include acceptance of a 32-bit FCS. The bench drives frames through these cases and compares each clock against a behavioural model of the line.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_OPEN = 2'd1,
        RX_RECV = 2'd2
    } rx_state_e;

    // destuffed bits kept back so that a flag's leading bits never reach a byte
    localparam int LAG_BITS = 6;

    localparam logic [2:0] ONES_STUFF = 3'd5;
    localparam logic [2:0] ONES_SIX   = 3'd6;
    localparam logic [2:0] ONES_SAT   = 3'd7;

endpackage

// File: rtl/hdlc_rx_linedec.sv
module hdlc_rx_linedec
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_bit,
    output logic bit_vld,
    output logic bit_val,
    output logic flag_hit,
    output logic abort_hit
);

    logic [2:0] ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (line_bit) begin
            ones_q <= (ones_q == ONES_SAT) ? ONES_SAT : ones_q + 3'd1;
        end else begin
            ones_q <= '0;
        end
    end

    assign flag_hit  = !line_bit && (ones_q == ONES_SIX);
    assign abort_hit =  line_bit && (ones_q == ONES_SIX);
    assign bit_vld   = line_bit ? (ones_q < ONES_STUFF)
                                : ((ones_q != ONES_STUFF) && (ones_q != ONES_SIX));
    assign bit_val   = line_bit;

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    input  logic din,
    output logic good
);

    logic [W-1:0] poly;
    logic [W-1:0] resid;
    logic [W-1:0] crc_q;
    logic [W-1:0] step;

    generate
        if (W == 32) begin : g_crc32
            assign poly  = 32'hEDB8_8320;
            assign resid = 32'hDEBB_20E3;
        end else begin : g_crc16
            assign poly  = 16'h8408;
            assign resid = 16'hF0B8;
        end
    endgenerate

    assign step = (crc_q >> 1) ^ ((crc_q[0] ^ din) ? poly : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (clear) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= step;
        end
    end

    assign good = (crc_q == resid);

endmodule

// File: rtl/hdlc_rx_handoff.sv
module hdlc_rx_handoff #(
    parameter int WINDOW = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       deliver,
    input  logic [7:0] deliver_byte,
    input  logic       rd_strobe,
    output logic       rdy,
    output logic [7:0] data,
    output logic       late
);

    localparam int WIN_W = $clog2(WINDOW + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

    logic [WIN_W-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy   <= 1'b0;
            data  <= '0;
            win_q <= '0;
        end else if (deliver) begin
            rdy   <= 1'b1;
            data  <= deliver_byte;
            win_q <= '0;
        end else if (rdy && rd_strobe) begin
            rdy   <= 1'b0;
        end else if (rdy) begin
            if (win_q == WIN_LAST) begin
                rdy <= 1'b0;
            end else begin
                win_q <= win_q + 1'b1;
            end
        end
    end

    assign late = !deliver && rdy && !rd_strobe && (win_q == WIN_LAST);

endmodule

// File: rtl/hdlc_rx_channel.sv
module hdlc_rx_channel
    import hdlc_rx_pkg::*;
#(
    parameter int CRC_W  = 16,
    parameter int WINDOW = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_bit,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       frame_valid,
    output logic       frame_err
);

    localparam int FCS_BYTES = CRC_W / 8;
    localparam int NBY_MAX   = FCS_BYTES + 1;
    localparam int NBY_W     = $clog2(NBY_MAX + 1);
    localparam int PF_W      = $clog2(FCS_BYTES + 1);
    localparam logic [2:0] LAG_FULL = 3'(LAG_BITS);

    rx_state_e st_q, st_d;

    logic bit_vld, bit_val, flag_hit, abort_hit;
    logic crc_good, late;

    logic [LAG_BITS-1:0] lag_q;
    logic [2:0]          lag_cnt_q;
    logic [7:0]          shf_q;
    logic [2:0]          bcnt_q;
    logic [NBY_W-1:0]    nby_q;
    logic [PF_W-1:0]     pfill_q;
    logic [7:0]          pipe_q [FCS_BYTES];
    logic                err_hold_q;

    logic       restart, push, lag_full, out_vld, byte_done, deliver;
    logic       frame_bad, end_bad, err_hold_d;
    logic [7:0] new_shf;

    hdlc_rx_linedec u_linedec (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_bit  (line_bit),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .flag_hit  (flag_hit),
        .abort_hit (abort_hit)
    );

    assign restart   = flag_hit || abort_hit;
    assign push      = bit_vld && (st_q != RX_HUNT);
    assign lag_full  = (lag_cnt_q == LAG_FULL);
    assign out_vld   = push && lag_full;
    assign new_shf   = {lag_q[0], shf_q[7:1]};
    assign byte_done = out_vld && (bcnt_q == 3'd7);
    assign deliver   = byte_done && (pfill_q == PF_W'(FCS_BYTES));

    hdlc_rx_crc #(.W(CRC_W)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart || (st_q == RX_HUNT)),
        .en    (out_vld),
        .din   (lag_q[0]),
        .good  (crc_good)
    );

    hdlc_rx_handoff #(.WINDOW(WINDOW)) u_handoff (
        .clk          (clk),
        .rst_n        (rst_n),
        .deliver      (deliver),
        .deliver_byte (pipe_q[0]),
        .rd_strobe    (rd_strobe),
        .rdy          (rx_ready),
        .data         (rx_data),
        .late         (late)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_HUNT: if (flag_hit)  st_d = RX_OPEN;
            RX_OPEN: if (abort_hit) st_d = RX_HUNT;
                     else if (out_vld) st_d = RX_RECV;
            RX_RECV: if (abort_hit) st_d = RX_HUNT;
                     else if (flag_hit) st_d = RX_OPEN;
            default: st_d = RX_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_HUNT;
        else        st_q <= st_d;
    end

    assign frame_bad  = (bcnt_q != 3'd0) || (nby_q < NBY_W'(NBY_MAX)) || !crc_good;
    assign end_bad    = flag_hit && (st_q == RX_RECV) && frame_bad;
    assign err_hold_d = (st_d == RX_RECV) && (err_hold_q || late);
    assign frame_valid = (st_q == RX_RECV);

    // datapath and status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lag_q      <= '0;
            lag_cnt_q  <= '0;
            shf_q      <= '0;
            bcnt_q     <= '0;
            nby_q      <= '0;
            pfill_q    <= '0;
            err_hold_q <= 1'b0;
            frame_err  <= 1'b0;
            for (int i = 0; i < FCS_BYTES; i++) pipe_q[i] <= '0;
        end else begin
            err_hold_q <= err_hold_d;
            frame_err  <= err_hold_d || end_bad;
            if (restart) begin
                lag_cnt_q <= '0;
                bcnt_q    <= '0;
                nby_q     <= '0;
                pfill_q   <= '0;
            end else if (push) begin
                lag_q <= {bit_val, lag_q[LAG_BITS-1:1]};
                if (!lag_full) begin
                    lag_cnt_q <= lag_cnt_q + 3'd1;
                end else begin
                    shf_q  <= new_shf;
                    bcnt_q <= bcnt_q + 3'd1;
                    if (bcnt_q == 3'd7) begin
                        if (nby_q != NBY_W'(NBY_MAX)) nby_q <= nby_q + 1'b1;
                        if (pfill_q == PF_W'(FCS_BYTES)) begin
                            for (int i = 0; i < FCS_BYTES - 1; i++) pipe_q[i] <= pipe_q[i+1];
                            pipe_q[FCS_BYTES-1] <= new_shf;
                        end else begin
                            for (int i = 0; i < FCS_BYTES; i++)
                                if (pfill_q == PF_W'(i)) pipe_q[i] <= new_shf;
                            pfill_q <= pfill_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_channel_chk.sv
module hdlc_rx_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_strobe,
    input logic rx_ready,
    input logic frame_valid,
    input logic frame_err,
    input logic flag_hit,
    input logic abort_hit
);

    logic [3:0] ready_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ready_age <= '0;
        else if (rx_ready) ready_age <= (ready_age == 4'd15) ? 4'd15 : ready_age + 4'd1;
        else               ready_age <= '0;
    end

    // R1
    close_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hit && frame_valid |=> !frame_valid);

    // R3
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> !frame_valid && !frame_err);

    // R4
    offer_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> frame_valid);

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && rd_strobe |=> !rx_ready);

    // R9
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> ready_age <= 4'd6);

    // R5
    end_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) && !frame_valid |-> $past(frame_valid));

    // R12
    idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hit && !frame_valid |=> !frame_valid);

endmodule

bind hdlc_rx_channel hdlc_rx_channel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .rx_ready    (rx_ready),
    .frame_valid (frame_valid),
    .frame_err   (frame_err),
    .flag_hit    (flag_hit),
    .abort_hit   (abort_hit)
);

// File: tb/hdlc_rx_channel_bench.sv
module hdlc_rx_channel_bench;

    localparam int FB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b1;
    logic rd = 1'b0;
    logic rd32 = 1'b0;
    logic [7:0] data, data32;
    logic rdy, valid, err, rdy32, valid32, err32;

    always #5 clk = ~clk;

    hdlc_rx_channel u_hdlc_rx_channel (
        .clk(clk), .rst_n(rst_n), .line_bit(line), .rd_strobe(rd),
        .rx_data(data), .rx_ready(rdy), .frame_valid(valid), .frame_err(err));

    hdlc_rx_channel #(.CRC_W(32)) u_hdlc_rx_channel_c32 (
        .clk(clk), .rst_n(rst_n), .line_bit(line), .rd_strobe(rd32),
        .rx_data(data32), .rx_ready(rdy32), .frame_valid(valid32), .frame_err(err32));

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ones, m_st, m_nbits, m_nbytes, m_win;
    logic [15:0] m_crc;
    logic [7:0] m_cur, m_data;
    bit m_rdy, m_hold, m_err;
    bit m_pend[$];
    logic [7:0] m_bq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ones = 0; m_st = 0; m_nbits = 0; m_nbytes = 0; m_win = 0;
            m_crc = 16'hFFFF; m_cur = 0; m_data = 0;
            m_rdy = 0; m_hold = 0; m_err = 0;
            m_pend.delete(); m_bq.delete();
        end else begin
            bit b, is_abort, is_flag, acc, endbad, late, dlv, ob, fb;
            logic [7:0] dbyte;
            b = line; is_abort = 0; is_flag = 0; acc = 0; endbad = 0; late = 0; dlv = 0; dbyte = 0;
            if (b) begin
                if (m_ones == 6) is_abort = 1;
                else if (m_ones < 5) acc = 1;
                if (m_ones < 7) m_ones++;
            end else begin
                if (m_ones == 6) is_flag = 1;
                else if (m_ones != 5) acc = 1;
                m_ones = 0;
            end
            if (is_abort || is_flag) begin
                if (is_flag && m_st == 2)
                    endbad = (m_nbits % 8 != 0) || (m_nbytes < FB + 1) || (m_crc != 16'hF0B8);
                m_st = is_flag ? 1 : 0;
                m_pend.delete(); m_bq.delete();
                m_nbits = 0; m_nbytes = 0; m_crc = 16'hFFFF;
            end else if (acc && m_st != 0) begin
                m_pend.push_back(b);
                if (m_pend.size() > 6) begin
                    ob = m_pend.pop_front();
                    m_st = 2;
                    fb = m_crc[0] ^ ob;
                    m_crc = m_crc >> 1;
                    if (fb) m_crc = m_crc ^ 16'h8408;
                    m_cur = {ob, m_cur[7:1]};
                    m_nbits++;
                    if (m_nbits % 8 == 0) begin
                        m_nbytes++;
                        m_bq.push_back(m_cur);
                        if (m_bq.size() > FB) begin
                            dlv = 1;
                            dbyte = m_bq.pop_front();
                        end
                    end
                end
            end
            if (dlv) begin
                m_rdy = 1; m_data = dbyte; m_win = 0;
            end else if (m_rdy && rd) begin
                m_rdy = 0;
            end else if (m_rdy) begin
                m_win++;
                if (m_win == 7) begin m_rdy = 0; late = 1; end
            end
            m_hold = (m_st == 2) && (m_hold || late);
            m_err = m_hold || endbad;
        end
    end

    // ---------------- compare, reader and observers ----------------
    int read_delay = 1;
    bit force_rd = 0;
    int age = 0;
    logic [7:0] cap[$];
    logic [7:0] cap32[$];
    int err_rises = 0, err32_rises = 0, valid_hi = 0;
    bit err_q = 0, err32_q = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(rdy === m_rdy, "R8/R9/R10 rx_ready", rdy, m_rdy);
            if (m_rdy) chk(data === m_data, "R2/R4 rx_data", data, m_data);
            chk(valid === (m_st == 2), "R1/R3/R12 frame_valid", valid, m_st == 2);
            chk(err === m_err, "R5/R6/R7/R9 frame_err", err, m_err);
            if (!rdy) age = 0; else age++;
            if (rdy && age == 1) cap.push_back(data);
            rd = force_rd || (read_delay != 0 && rdy && age == read_delay);
            if (err && !err_q) err_rises++;
            err_q = err;
            if (valid) valid_hi++;
            if (rdy32 && !rd32) begin cap32.push_back(data32); rd32 = 1; end
            else rd32 = 0;
            if (err32 && !err32_q) err32_rises++;
            err32_q = err32;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [31:0] fcs_of(input logic [7:0] pl[$], input int w);
        logic [31:0] c, poly;
        bit fb;
        c = (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        poly = (w == 32) ? 32'hEDB8_8320 : 32'h0000_8408;
        foreach (pl[i]) for (int k = 0; k < 8; k++) begin
            fb = c[0] ^ pl[i][k];
            c = c >> 1;
            if (fb) c = c ^ poly;
        end
        c = ~c;
        if (w != 32) c[31:16] = 16'h0;
        return c;
    endfunction

    task automatic send_bit(input bit b);
        @(negedge clk);
        line = b;
    endtask

    task automatic send_flag;
        send_bit(0);
        for (int k = 0; k < 6; k++) send_bit(1);
        send_bit(0);
    endtask

    task automatic send_body(input logic [7:0] pl[$], input int w, input bit corrupt, input int extra);
        logic [31:0] f;
        bit bits[$];
        int ones;
        f = fcs_of(pl, w);
        foreach (pl[i]) for (int k = 0; k < 8; k++) bits.push_back(pl[i][k]);
        for (int k = 0; k < w; k++) bits.push_back(f[k]);
        if (corrupt) bits[0] = ~bits[0];
        for (int k = 0; k < extra; k++) bits.push_back(1'b0);
        ones = 0;
        foreach (bits[i]) begin
            send_bit(bits[i]);
            if (bits[i]) begin
                ones++;
                if (ones == 5) begin send_bit(0); ones = 0; end
            end else ones = 0;
        end
        send_flag;
    endtask

    function automatic bit same(input logic [7:0] a[$], input logic [7:0] b[$]);
        if (a.size() != b.size()) return 0;
        foreach (a[i]) if (a[i] !== b[i]) return 0;
        return 1;
    endfunction

    task automatic clear_obs;
        cap.delete(); cap32.delete();
        err_rises = 0; err32_rises = 0; valid_hi = 0;
    endtask

    task automatic run_frame(input logic [7:0] pl[$], input int w, input bit corrupt, input int extra,
                             input int dly, input int exp_err, input bit check_cap, input string tag);
        read_delay = dly;
        clear_obs;
        send_flag;
        send_body(pl, w, corrupt, extra);
        repeat (3) send_flag;
        chk(err_rises == exp_err, {tag, " error pulses"}, err_rises, exp_err);
        if (check_cap) chk(same(cap, pl), {tag, " delivered bytes"}, cap.size(), pl.size());
    endtask

    initial begin
        logic [7:0] pa[$];
        logic [7:0] pb[$];
        logic [7:0] empty[$];
        pa = '{8'hA5, 8'hFF, 8'h7E, 8'h3E, 8'h01};
        pb = '{8'h1F, 8'hC3};

        rst_n = 0; line = 1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 R8: reset state
        chk(rdy === 1'b0, "R8 reset rx_ready", rdy, 0);
        chk(valid === 1'b0, "R1 reset frame_valid", valid, 0);
        chk(err === 1'b0, "R5 reset frame_err", err, 0);

        // R12: idle flags
        clear_obs;
        repeat (6) send_flag;
        chk(valid_hi == 0, "R12 idle flags", valid_hi, 0);

        // R2 R4: stuffing-heavy payload, prompt read
        run_frame(pa, 16, 0, 0, 1, 0, 1, "R2/R4");
        // R8: read on the last edge of the window
        run_frame(pa, 16, 0, 0, 7, 0, 1, "R8");
        // R6: bad FCS
        run_frame(pa, 16, 1, 0, 1, 1, 0, "R6");
        // R5: three extra bits before the closing flag
        run_frame(pa, 16, 0, 3, 1, 1, 1, "R5");
        // R7: FCS only, no payload
        run_frame(empty, 16, 0, 0, 1, 1, 1, "R7");
        // R9: backend never reads
        run_frame(pa, 16, 0, 0, 0, 1, 1, "R9");
        chk(err === 1'b0, "R9 error released after frame", err, 0);

        // R10: strobes while nothing is ready
        force_rd = 1;
        repeat (2) send_flag;
        chk(rdy === 1'b0, "R10 rx_ready idle", rdy, 0);
        force_rd = 0;
        run_frame(pb, 16, 0, 0, 2, 0, 1, "R10");

        // R1: two frames sharing one flag
        read_delay = 3;
        clear_obs;
        send_flag;
        send_body(pa, 16, 0, 0);
        send_body(pb, 16, 0, 0);
        repeat (3) send_flag;
        chk(same(cap, {pa, pb}), "R1 shared flag bytes", cap.size(), pa.size() + pb.size());
        chk(err_rises == 0, "R1 shared flag errors", err_rises, 0);

        // R3: abort in mid frame
        clear_obs;
        send_flag;
        for (int i = 0; i < 16; i++) send_bit(i % 3 == 0);
        for (int i = 0; i < 9; i++) send_bit(1);
        @(negedge clk);
        chk(valid_hi > 0, "R3 frame opened before abort", valid_hi, 1);
        chk(valid === 1'b0, "R3 frame_valid after abort", valid, 0);
        chk(err_rises == 0, "R3 no error on abort", err_rises, 0);
        chk(cap.size() == 0, "R3 nothing delivered", cap.size(), 0);
        repeat (3) send_flag;

        // R11: 32-bit FCS frame
        read_delay = 1;
        run_frame(pa, 32, 0, 0, 1, 1, 0, "R11 16-bit instance");
        chk(same(cap32, pa), "R11 32-bit bytes", cap32.size(), pa.size());
        chk(err32_rises == 0, "R11 32-bit errors", err32_rises, 0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule